// File: doc/BRIEF.md
# Dual-Mode Translation Lookaside Buffer with Invalidation

This block keeps recently completed address translations so that most memory accesses skip the page table walk. It has two separate direct-mapped arrays, one for user-mode accesses and one for supervisor-mode accesses. Each entry holds a physical frame number and three attribute flags: read-only, cache-inhibit and modified. A lookup port returns hit, frame and flags in the same cycle. A fill port writes a completed translation from the table walker into the array of the mode that was walked.

Translations are removed by side effects of ordinary register and bus cycles. Reading the control register empties both arrays. Writing the control register empties one array, chosen by the value written. Writing either segment table pointer register empties that mode's array. A write cycle in the purge function-code space removes one page's translation from both arrays. All valid bits are flip-flops, so every invalidation takes effect at the clock edge that ends its cycle.

Top module: `dual_tlb`

## Requirements
- R1: After a fill in a mode's array, a read lookup of the same page number in that mode hits and returns the filled frame and the read-only, cache-inhibit and modified flags. The other mode's array is left unchanged.
- R2: The index is the low log2(DEPTH) bits of the virtual page number and the tag is the remaining upper bits. A fill at an index whose stored tag differs replaces that entry, so the old page then misses.
- R3: A read cycle at register address 2 (the control register) invalidates every entry in both arrays.
- R4: A write cycle at register address 2 with data 0 invalidates every user entry. Data 0x00008000 invalidates every supervisor entry. Any other data value has no effect.
- R5: A write cycle at register address 1 (user pointer) invalidates every user entry. A write at register address 0 (supervisor pointer) invalidates every supervisor entry.
- R6: A purge strobe with function code 3 invalidates the entry for that page number in both arrays, but only where the stored tag matches. A purge strobe with any other function code has no effect.
- R7: A write lookup that matches an entry whose modified flag is 0 reports a miss. A write lookup that matches an entry whose modified flag is 1 reports a hit.
- R8: When a flush or purge and a fill reach the same entry in the same cycle, the invalidation wins and a later lookup misses. A flush of one mode does not block a fill in the other mode.
- R9: After reset, every lookup in both modes misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_super | input | 1 | Lookup mode: 1 supervisor, 0 user |
| lk_write | input | 1 | Lookup is for a write access |
| lk_hit | output | 1 | Usable translation found |
| lk_frame | output | FRAME_W | Physical frame of the matching entry |
| lk_ro | output | 1 | Read-only flag of the matching entry |
| lk_ci | output | 1 | Cache-inhibit flag of the matching entry |
| lk_dirty | output | 1 | Modified flag of the matching entry |
| fill_en | input | 1 | Write a translation from the walker |
| fill_super | input | 1 | Mode array to fill |
| fill_vpn | input | VPN_W | Page number being filled |
| fill_frame | input | FRAME_W | Frame being filled |
| fill_ro | input | 1 | Read-only flag to store |
| fill_ci | input | 1 | Cache-inhibit flag to store |
| fill_dirty | input | 1 | Modified flag to store |
| reg_addr | input | 2 | Register select: 0 supervisor pointer, 1 user pointer, 2 control |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| pg_strobe | input | 1 | Bus write cycle strobe for purge decoding |
| pg_fc | input | 3 | Function code of that cycle |
| pg_vpn | input | VPN_W | Page number of that cycle |

## Verification
A valid bit that is set when it should be clear shows up as a stale lk_hit. The stale hit appears on the first lookup of that page after the flush or purge edge, with no extra delay, because lookup reads the arrays combinationally. A valid bit lost or a wrong index or tag shows as a miss or a wrong lk_frame on the first lookup after the fill. A wrong modified-flag rule shows only on write lookups, as a hit where a miss is due. The bench therefore looks up the affected pages in both modes right after each invalidating cycle. It also checks the pages that must survive, so an over-broad flush is caught as well.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef struct packed {
    logic ro;
    logic ci;
    logic dirty;
  } attr_t;

  localparam logic [1:0]  RA_SPTR     = 2'd0;
  localparam logic [1:0]  RA_UPTR     = 2'd1;
  localparam logic [1:0]  RA_CTL      = 2'd2;
  localparam logic [2:0]  FC_PURGE    = 3'd3;
  localparam logic [31:0] KEY_USR_CLR = 32'h0000_0000;
  localparam logic [31:0] KEY_SUP_CLR = 32'h0000_8000;
endpackage

// File: rtl/tlb_rst_sync.sv
module tlb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/tlb_inval_dec.sv
module tlb_inval_dec
  import tlb_pkg::*;
(
  input  logic [1:0]  reg_addr,
  input  logic        reg_rd,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  input  logic        pg_strobe,
  input  logic [2:0]  pg_fc,
  output logic        flush_usr,
  output logic        flush_sup,
  output logic        pg_go
);
  logic ctl_rd, ctl_wr, uptr_wr, sptr_wr;

  always_comb begin
    ctl_rd    = reg_rd && (reg_addr == RA_CTL);
    ctl_wr    = reg_wr && (reg_addr == RA_CTL);
    uptr_wr   = reg_wr && (reg_addr == RA_UPTR);
    sptr_wr   = reg_wr && (reg_addr == RA_SPTR);
    flush_usr = ctl_rd || uptr_wr || (ctl_wr && (reg_wdata == KEY_USR_CLR));
    flush_sup = ctl_rd || sptr_wr || (ctl_wr && (reg_wdata == KEY_SUP_CLR));
    pg_go     = pg_strobe && (pg_fc == FC_PURGE);
  end
endmodule

// File: rtl/tlb_way.sv
module tlb_way
  import tlb_pkg::*;
#(
  parameter int VPN_W   = 20,
  parameter int FRAME_W = 20,
  parameter int DEPTH   = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               lk_hit,
  output logic [FRAME_W-1:0] lk_frame,
  output attr_t              lk_attr,
  input  logic               fill_en,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [FRAME_W-1:0] fill_frame,
  input  attr_t              fill_attr,
  input  logic               flush,
  input  logic               pg_go,
  input  logic [VPN_W-1:0]   pg_vpn,
  output logic [DEPTH-1:0]   vld_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int TAG_W = VPN_W - IDX_W;

  logic [DEPTH-1:0]   vld_q, vld_d;
  logic [TAG_W-1:0]   tag_q   [DEPTH];
  logic [FRAME_W-1:0] frame_q [DEPTH];
  attr_t              attr_q  [DEPTH];

  logic [IDX_W-1:0] lk_idx, fill_idx, pg_idx;
  logic [TAG_W-1:0] lk_tag, fill_tag, pg_tag;
  logic             pg_kill;

  always_comb begin
    lk_idx   = lk_vpn[IDX_W-1:0];
    lk_tag   = lk_vpn[VPN_W-1:IDX_W];
    fill_idx = fill_vpn[IDX_W-1:0];
    fill_tag = fill_vpn[VPN_W-1:IDX_W];
    pg_idx   = pg_vpn[IDX_W-1:0];
    pg_tag   = pg_vpn[VPN_W-1:IDX_W];
  end

  // Lookup reads the registered arrays directly.
  always_comb begin
    lk_hit   = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    lk_frame = frame_q[lk_idx];
    lk_attr  = attr_q[lk_idx];
  end

  // A purge kills a matching stored entry, or any fill landing on its index.
  always_comb begin
    pg_kill = pg_go &&
              ((vld_q[pg_idx] && (tag_q[pg_idx] == pg_tag)) ||
               (fill_en && (fill_idx == pg_idx)));
  end

  // Next-state for valid bits: invalidations are applied after the fill.
  always_comb begin
    vld_d = vld_q;
    if (fill_en) vld_d[fill_idx] = 1'b1;
    if (pg_kill) vld_d[pg_idx]   = 1'b0;
    if (flush)   vld_d           = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // Payload storage carries no reset; the valid bits guard it.
  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx]   <= fill_tag;
      frame_q[fill_idx] <= fill_frame;
      attr_q[fill_idx]  <= fill_attr;
    end
  end

  assign vld_o = vld_q;
endmodule

// File: rtl/dual_tlb.sv
module dual_tlb
  import tlb_pkg::*;
#(
  parameter int VPN_W   = 20,
  parameter int FRAME_W = 20,
  parameter int DEPTH   = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic               lk_super,
  input  logic               lk_write,
  output logic               lk_hit,
  output logic [FRAME_W-1:0] lk_frame,
  output logic               lk_ro,
  output logic               lk_ci,
  output logic               lk_dirty,
  input  logic               fill_en,
  input  logic               fill_super,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic               fill_ro,
  input  logic               fill_ci,
  input  logic               fill_dirty,
  input  logic [1:0]         reg_addr,
  input  logic               reg_rd,
  input  logic               reg_wr,
  input  logic [31:0]        reg_wdata,
  input  logic               pg_strobe,
  input  logic [2:0]         pg_fc,
  input  logic [VPN_W-1:0]   pg_vpn
);
  localparam int NMODE = 2;

  logic rst_n_sync;
  logic flush_usr, flush_sup, pg_go;

  logic               way_hit   [NMODE];
  logic [FRAME_W-1:0] way_frame [NMODE];
  attr_t              way_attr  [NMODE];
  logic [DEPTH-1:0]   way_vld   [NMODE];
  logic [DEPTH-1:0]   usr_vld, sup_vld;
  attr_t              fill_attr, sel_attr;
  logic               sel_hit;

  tlb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  tlb_inval_dec u_dec (
    .reg_addr  (reg_addr),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .pg_strobe (pg_strobe),
    .pg_fc     (pg_fc),
    .flush_usr (flush_usr),
    .flush_sup (flush_sup),
    .pg_go     (pg_go)
  );

  always_comb begin
    fill_attr = '{ro: fill_ro, ci: fill_ci, dirty: fill_dirty};
  end

  // Mode 0 is user, mode 1 is supervisor.
  for (genvar m = 0; m < NMODE; m++) begin : g_mode
    logic mode_fill, mode_flush;
    always_comb begin
      mode_fill  = fill_en && (fill_super == (m == 1));
      mode_flush = (m == 1) ? flush_sup : flush_usr;
    end
    tlb_way #(
      .VPN_W   (VPN_W),
      .FRAME_W (FRAME_W),
      .DEPTH   (DEPTH)
    ) u_way (
      .clk        (clk),
      .rst_n      (rst_n_sync),
      .lk_vpn     (lk_vpn),
      .lk_hit     (way_hit[m]),
      .lk_frame   (way_frame[m]),
      .lk_attr    (way_attr[m]),
      .fill_en    (mode_fill),
      .fill_vpn   (fill_vpn),
      .fill_frame (fill_frame),
      .fill_attr  (fill_attr),
      .flush      (mode_flush),
      .pg_go      (pg_go),
      .pg_vpn     (pg_vpn),
      .vld_o      (way_vld[m])
    );
  end

  assign usr_vld = way_vld[0];
  assign sup_vld = way_vld[1];

  // A write to a clean page misses so the walker records the modification.
  always_comb begin
    sel_hit  = lk_super ? way_hit[1]   : way_hit[0];
    sel_attr = lk_super ? way_attr[1]  : way_attr[0];
    lk_frame = lk_super ? way_frame[1] : way_frame[0];
    lk_ro    = sel_attr.ro;
    lk_ci    = sel_attr.ci;
    lk_dirty = sel_attr.dirty;
    lk_hit   = sel_hit && !(lk_write && !sel_attr.dirty);
  end
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
  parameter int VPN_W = 20,
  parameter int DEPTH = 1024
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       reg_addr,
  input logic             reg_rd,
  input logic             reg_wr,
  input logic [31:0]      reg_wdata,
  input logic             pg_strobe,
  input logic [2:0]       pg_fc,
  input logic [VPN_W-1:0] pg_vpn,
  input logic [VPN_W-1:0] lk_vpn,
  input logic             lk_write,
  input logic             lk_hit,
  input logic             lk_dirty,
  input logic [DEPTH-1:0] usr_vld,
  input logic [DEPTH-1:0] sup_vld
);
  assert_ctl_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd2) |=> (usr_vld == '0 && sup_vld == '0));

  assert_ctl_zero_user_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && reg_wdata == 32'h0) |=> (usr_vld == '0));

  assert_ctl_key_super_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && reg_wdata == 32'h8000) |=> (sup_vld == '0));

  assert_uptr_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1) |=> (usr_vld == '0));

  assert_sptr_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0) |=> (sup_vld == '0));

  assert_purge_misses_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_strobe && pg_fc == 3'd3) |=> ((lk_vpn != $past(pg_vpn)) || !lk_hit));

  assert_clean_write_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_write && lk_hit) |-> lk_dirty);

  assert_reset_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (usr_vld == '0 && sup_vld == '0));
endmodule

bind dual_tlb tlb_chk #(.VPN_W(VPN_W), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_rd    (reg_rd),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .pg_strobe (pg_strobe),
  .pg_fc     (pg_fc),
  .pg_vpn    (pg_vpn),
  .lk_vpn    (lk_vpn),
  .lk_write  (lk_write),
  .lk_hit    (lk_hit),
  .lk_dirty  (lk_dirty),
  .usr_vld   (usr_vld),
  .sup_vld   (sup_vld)
);

// File: tb/test_dual_tlb.sv
`timescale 1ns/1ps
module test_dual_tlb;
  localparam int VPN_W   = 20;
  localparam int FRAME_W = 20;
  localparam int DEPTH   = 16;

  logic               clk = 1'b0;
  logic               rst_n;
  logic [VPN_W-1:0]   lk_vpn;
  logic               lk_super, lk_write;
  logic               lk_hit, lk_ro, lk_ci, lk_dirty;
  logic [FRAME_W-1:0] lk_frame;
  logic               fill_en, fill_super, fill_ro, fill_ci, fill_dirty;
  logic [VPN_W-1:0]   fill_vpn;
  logic [FRAME_W-1:0] fill_frame;
  logic [1:0]         reg_addr;
  logic               reg_rd, reg_wr;
  logic [31:0]        reg_wdata;
  logic               pg_strobe;
  logic [2:0]         pg_fc;
  logic [VPN_W-1:0]   pg_vpn;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  dual_tlb #(.VPN_W(VPN_W), .FRAME_W(FRAME_W), .DEPTH(DEPTH)) i_dual_tlb (
    .clk(clk), .rst_n(rst_n),
    .lk_vpn(lk_vpn), .lk_super(lk_super), .lk_write(lk_write),
    .lk_hit(lk_hit), .lk_frame(lk_frame), .lk_ro(lk_ro), .lk_ci(lk_ci), .lk_dirty(lk_dirty),
    .fill_en(fill_en), .fill_super(fill_super), .fill_vpn(fill_vpn), .fill_frame(fill_frame),
    .fill_ro(fill_ro), .fill_ci(fill_ci), .fill_dirty(fill_dirty),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .pg_strobe(pg_strobe), .pg_fc(pg_fc), .pg_vpn(pg_vpn)
  );

  // Operation codes of the vector table.
  localparam logic [2:0] OP_FILL = 3'd0, OP_LKR = 3'd1, OP_LKW = 3'd2, OP_CTLRD = 3'd3,
                         OP_CTLWR = 3'd4, OP_PTRWR = 3'd5, OP_PURGE = 3'd6;

  typedef struct packed {
    logic [2:0]  op;
    logic        sup;
    logic [19:0] vpn;
    logic [31:0] dat;   // frame for fills, write data for control writes
    logic [2:0]  attr;  // {ro, ci, dirty}
    logic [2:0]  fc;
    logic        xhit;
    logic [19:0] xfrm;
    logic [3:0]  req;
  } vec_t;

  function automatic vec_t v(logic [2:0] op, logic sup, logic [19:0] vpn, logic [31:0] dat,
                             logic [2:0] attr, logic [2:0] fc, logic xhit, logic [19:0] xfrm,
                             logic [3:0] req);
    v = '{op: op, sup: sup, vpn: vpn, dat: dat, attr: attr, fc: fc,
          xhit: xhit, xfrm: xfrm, req: req};
  endfunction

  localparam int NV = 42;
  localparam vec_t TBL [NV] = '{
    v(OP_FILL,  0, 20'h00003, 32'h00AAA, 3'b011, 0, 0, 0, 1),
    v(OP_FILL,  1, 20'h00003, 32'h00BBB, 3'b001, 0, 0, 0, 1),
    v(OP_LKR,   0, 20'h00003, 0, 0, 0, 1, 20'h00AAA, 1),     // R1
    v(OP_LKR,   1, 20'h00003, 0, 0, 0, 1, 20'h00BBB, 1),     // R1
    v(OP_LKR,   0, 20'h00013, 0, 0, 0, 0, 0, 2),             // R2 same index, other tag
    v(OP_FILL,  0, 20'h00013, 32'h00CCC, 3'b000, 0, 0, 0, 2),
    v(OP_LKR,   0, 20'h00003, 0, 0, 0, 0, 0, 2),             // R2 replaced
    v(OP_LKR,   0, 20'h00013, 0, 0, 0, 1, 20'h00CCC, 2),     // R2
    v(OP_LKW,   0, 20'h00013, 0, 0, 0, 0, 0, 7),             // R7 clean write misses
    v(OP_FILL,  0, 20'h00005, 32'h00555, 3'b001, 0, 0, 0, 7),
    v(OP_LKW,   0, 20'h00005, 0, 0, 0, 1, 20'h00555, 7),     // R7 dirty write hits
    v(OP_CTLWR, 0, 0, 32'h8000, 0, 0, 0, 0, 4),
    v(OP_LKR,   1, 20'h00003, 0, 0, 0, 0, 0, 4),             // R4 super flushed
    v(OP_LKR,   0, 20'h00005, 0, 0, 0, 1, 20'h00555, 4),     // R4 user kept
    v(OP_FILL,  1, 20'h00003, 32'h00BBB, 3'b001, 0, 0, 0, 4),
    v(OP_CTLWR, 0, 0, 32'h1234, 0, 0, 0, 0, 4),
    v(OP_LKR,   1, 20'h00003, 0, 0, 0, 1, 20'h00BBB, 4),     // R4 other value ignored
    v(OP_LKR,   0, 20'h00005, 0, 0, 0, 1, 20'h00555, 4),     // R4
    v(OP_CTLWR, 0, 0, 32'h0, 0, 0, 0, 0, 4),
    v(OP_LKR,   0, 20'h00005, 0, 0, 0, 0, 0, 4),             // R4 user flushed
    v(OP_LKR,   1, 20'h00003, 0, 0, 0, 1, 20'h00BBB, 4),     // R4 super kept
    v(OP_FILL,  0, 20'h00005, 32'h00555, 3'b001, 0, 0, 0, 5),
    v(OP_PTRWR, 0, 0, 0, 0, 0, 0, 0, 5),
    v(OP_LKR,   0, 20'h00005, 0, 0, 0, 0, 0, 5),             // R5 user pointer
    v(OP_LKR,   1, 20'h00003, 0, 0, 0, 1, 20'h00BBB, 5),     // R5
    v(OP_PTRWR, 1, 0, 0, 0, 0, 0, 0, 5),
    v(OP_LKR,   1, 20'h00003, 0, 0, 0, 0, 0, 5),             // R5 super pointer
    v(OP_FILL,  0, 20'h00007, 32'h00777, 3'b001, 0, 0, 0, 3),
    v(OP_FILL,  1, 20'h00007, 32'h00778, 3'b001, 0, 0, 0, 3),
    v(OP_CTLRD, 0, 0, 0, 0, 0, 0, 0, 3),
    v(OP_LKR,   0, 20'h00007, 0, 0, 0, 0, 0, 3),             // R3
    v(OP_LKR,   1, 20'h00007, 0, 0, 0, 0, 0, 3),             // R3
    v(OP_FILL,  0, 20'h00029, 32'h00129, 3'b001, 0, 0, 0, 6),
    v(OP_FILL,  1, 20'h00039, 32'h00139, 3'b001, 0, 0, 0, 6),
    v(OP_PURGE, 0, 20'h00029, 0, 0, 3'd1, 0, 0, 6),
    v(OP_LKR,   0, 20'h00029, 0, 0, 0, 1, 20'h00129, 6),     // R6 other fc ignored
    v(OP_PURGE, 0, 20'h00029, 0, 0, 3'd3, 0, 0, 6),
    v(OP_LKR,   0, 20'h00029, 0, 0, 0, 0, 0, 6),             // R6 purged
    v(OP_LKR,   1, 20'h00039, 0, 0, 0, 1, 20'h00139, 6),     // R6 tag differs, kept
    v(OP_FILL,  1, 20'h00029, 32'h00229, 3'b001, 0, 0, 0, 6),
    v(OP_PURGE, 0, 20'h00029, 0, 0, 3'd3, 0, 0, 6),
    v(OP_LKR,   1, 20'h00029, 0, 0, 0, 0, 0, 6)              // R6 super purged
  };

  task automatic idle();
    fill_en = 0; fill_super = 0; fill_vpn = '0; fill_frame = '0;
    fill_ro = 0; fill_ci = 0; fill_dirty = 0;
    reg_addr = 2'd3; reg_rd = 0; reg_wr = 0; reg_wdata = '0;
    pg_strobe = 0; pg_fc = '0; pg_vpn = '0;
  endtask

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic lookup(logic sup, logic [19:0] vpn, logic wr, logic xhit, logic [19:0] xfrm,
                        string req);
    @(negedge clk);
    lk_super = sup; lk_vpn = vpn; lk_write = wr;
    #1;
    check(lk_hit == xhit, req, $sformatf("hit vpn=%0h", vpn), 32'(lk_hit), 32'(xhit));
    if (xhit)
      check(lk_frame == xfrm, req, $sformatf("frame vpn=%0h", vpn), 32'(lk_frame), 32'(xfrm));
  endtask

  task automatic run_vec(vec_t e);
    if (e.op == OP_LKR || e.op == OP_LKW) begin
      lookup(e.sup, e.vpn, e.op == OP_LKW, e.xhit, e.xfrm, $sformatf("R%0d", e.req));
    end else begin
      @(negedge clk);
      case (e.op)
        OP_FILL: begin
          fill_en = 1; fill_super = e.sup; fill_vpn = e.vpn; fill_frame = e.dat[19:0];
          {fill_ro, fill_ci, fill_dirty} = e.attr;
        end
        OP_CTLRD: begin reg_addr = 2'd2; reg_rd = 1; end
        OP_CTLWR: begin reg_addr = 2'd2; reg_wr = 1; reg_wdata = e.dat; end
        OP_PTRWR: begin reg_addr = e.sup ? 2'd0 : 2'd1; reg_wr = 1; end
        OP_PURGE: begin pg_strobe = 1; pg_fc = e.fc; pg_vpn = e.vpn; end
        default: ;
      endcase
      @(posedge clk);
      #1 idle();
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    idle();
    lk_vpn = '0; lk_super = 0; lk_write = 0;
    do_reset();

    // R9: empty after reset
    lookup(0, 20'h00003, 0, 0, 0, "R9");
    lookup(1, 20'h00003, 0, 0, 0, "R9");

    for (int i = 0; i < NV; i++) run_vec(TBL[i]);

    // R1: stored flags come back
    run_vec(v(OP_FILL, 1, 20'h0000B, 32'h00BBA, 3'b110, 0, 0, 0, 1));
    lookup(1, 20'h0000B, 0, 1, 20'h00BBA, "R1");
    check({lk_ro, lk_ci, lk_dirty} == 3'b110, "R1", "flags",
          32'({lk_ro, lk_ci, lk_dirty}), 32'h6);
    lookup(0, 20'h0000B, 0, 0, 0, "R1");

    // R8: user flush and user fill in the same cycle
    @(negedge clk);
    fill_en = 1; fill_super = 0; fill_vpn = 20'h00004; fill_frame = 20'h00444; fill_dirty = 1;
    reg_addr = 2'd2; reg_wr = 1; reg_wdata = 32'h0;
    @(posedge clk); #1 idle();
    lookup(0, 20'h00004, 0, 0, 0, "R8");

    // R8: user flush does not block a supervisor fill
    @(negedge clk);
    fill_en = 1; fill_super = 1; fill_vpn = 20'h00004; fill_frame = 20'h00445; fill_dirty = 1;
    reg_addr = 2'd2; reg_wr = 1; reg_wdata = 32'h0;
    @(posedge clk); #1 idle();
    lookup(1, 20'h00004, 0, 1, 20'h00445, "R8");

    // R8: purge and fill on the same entry
    @(negedge clk);
    fill_en = 1; fill_super = 0; fill_vpn = 20'h00006; fill_frame = 20'h00666; fill_dirty = 1;
    pg_strobe = 1; pg_fc = 3'd3; pg_vpn = 20'h00006;
    @(posedge clk); #1 idle();
    lookup(0, 20'h00006, 0, 0, 0, "R8");

    // R9: reset in the middle of operation
    run_vec(v(OP_FILL, 0, 20'h0000A, 32'h00AA0, 3'b001, 0, 0, 0, 9));
    lookup(0, 20'h0000A, 0, 1, 20'h00AA0, "R9");
    do_reset();
    lookup(0, 20'h0000A, 0, 0, 0, "R9");
    lookup(1, 20'h00004, 0, 0, 0, "R9");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule